// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Clamp Flag

This block performs one 32-bit saturating operation per cycle, chosen by a 4-bit opcode. It covers signed and unsigned addition and subtraction, signed doubling, and clamping a word to a variable bit width. The width clamp comes in signed and unsigned forms, and each form works either on the whole word or on the two 16-bit halves separately. When an operation has to limit its result, a sticky flag is set. The flag stays set until a dedicated clear input is raised or reset is applied.

The result is registered and only updates in a cycle where `op_valid` is high. Otherwise it holds its last value. The flag can be cleared and set in the same cycle, and setting takes priority, so a clamp event in that cycle is never lost. The datapath width is a parameter with a default of 32. The clamp width input is `log2(DATA_W)` bits wide.

Top module: `sat_alu`

## Requirements
- R1: After reset, `result` is 0 and `sat_flag` is 0.
- R2: Opcode 0 is signed add and opcode 1 is signed subtract. Signed add overflows when the operands share a sign and the sum's sign differs from `opa`. Signed subtract overflows when the operands differ in sign and the difference's sign differs from `opa`. On overflow the result is 0x7FFFFFFF if `opa` is non-negative and 0x80000000 if it is negative. Otherwise the result is the wrapped sum or difference.
- R3: Opcode 2 doubles `opa` with saturation. A signed input of 0x40000000 or more gives 0x7FFFFFFF. A signed input of 0xC0000000 or less gives 0x80000000, and this includes 0xC0000000 itself, which counts as a clamp. Any other input gives `opa` shifted left by one.
- R4: Opcode 3 is unsigned add, which gives 0xFFFFFFFF on carry out. Opcode 4 is unsigned subtract, which gives 0 when `opb` is greater than `opa`.
- R5: Opcode 5 clamps `opa` as a signed value to the range -(2^n) .. 2^n-1, where n is `sat_width`. With n=31 it never clamps. With n=0 the range is -1..0.
- R6: Opcode 6 clamps `opa` as a signed value to the range 0 .. 2^n-1. Negative inputs give 0.
- R7: Opcode 7 applies the signed clamp of R5 and opcode 8 applies the unsigned clamp of R6. Each works on the two 16-bit halves of `opa` independently: each half is sign-extended, clamped to the same n, and packed back into the bits it came from.
- R8: `sat_flag` is set in the cycle after a valid operation clamps. No arithmetic operation clears it, and an operation with `op_valid` low never sets it.
- R9: `flag_clr` clears `sat_flag` on the next edge. If a valid clamp happens in the same cycle, the flag is set instead.
- R10: While `op_valid` is low, `result` holds its value. Opcodes 9 to 15 produce 0 and never clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Perform the operation this cycle |
| op | input | 4 | Operation select |
| opa | input | 32 | First operand; the only operand for doubling and clamping |
| opb | input | 32 | Second operand for add and subtract |
| sat_width | input | 5 | Clamp width n for opcodes 5 to 8 |
| flag_clr | input | 1 | Clear the sticky flag |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky clamp flag |

## Verification
The bench drives both extremes of the width input. With n=0 the signed range is -1..0. With n=31 a signed clamp never fires, but an unsigned clamp still zeroes negative values. An off-by-one in the mask or in the shift-based overflow detector shows up as a wrong limit or as a missing or spurious flag. The doubling tests hit 0xC0000000 exactly, which must clamp and set the flag, and its neighbour 0xC0000001, which must not. The halfword tests include one lane that clamps while the other passes unchanged, so a design that shares one clamp decision across both lanes, or that misses the sign extension, corrupts the other half. Tests where the flag is cleared while a clamp occurs, and where the flag must stay set through later clean operations, catch a wrong set/clear priority and a flag that is not actually sticky.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_SADD   = 4'd0,
      OP_SSUB   = 4'd1,
      OP_SDBL   = 4'd2,
      OP_UADD   = 4'd3,
      OP_USUB   = 4'd4,
      OP_SSAT   = 4'd5,
      OP_USAT   = 4'd6,
      OP_SSAT2  = 4'd7,
      OP_USAT2  = 4'd8
   } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
   import sat_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   output logic [W-1:0]    res,
   output logic            clamped
);
   localparam logic [W-1:0] SMAX  = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN  = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] DBL_LO = {2'b11, {(W-2){1'b0}}};

   logic [W:0]   usum;
   logic [W-1:0] diff;
   logic         sovf_add, sovf_sub;

   always_comb begin
      usum     = {1'b0, a} + {1'b0, b};
      diff     = a - b;
      sovf_add = (usum[W-1] ^ a[W-1]) & ~(a[W-1] ^ b[W-1]);
      sovf_sub = (diff[W-1] ^ a[W-1]) &  (a[W-1] ^ b[W-1]);
      res      = '0;
      clamped  = 1'b0;
      case (op)
         OP_SADD: begin
            clamped = sovf_add;
            res     = sovf_add ? (a[W-1] ? SMIN : SMAX) : usum[W-1:0];
         end
         OP_SSUB: begin
            clamped = sovf_sub;
            res     = sovf_sub ? (a[W-1] ? SMIN : SMAX) : diff;
         end
         OP_SDBL: begin
            if (!a[W-1] && a[W-2]) begin
               clamped = 1'b1;
               res     = SMAX;
            end else if (a[W-1] && (!a[W-2] || a == DBL_LO)) begin
               clamped = 1'b1;
               res     = SMIN;
            end else begin
               res     = {a[W-2:0], 1'b0};
            end
         end
         OP_UADD: begin
            clamped = usum[W];
            res     = usum[W] ? '1 : usum[W-1:0];
         end
         OP_USUB: begin
            clamped = (a < b);
            res     = (a < b) ? '0 : diff;
         end
         default: begin
            res     = '0;
            clamped = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
   parameter int W      = 32,
   parameter bit SIGNED = 1'b1,
   localparam int NW    = $clog2(W)
) (
   input  logic [W-1:0]  val,
   input  logic [NW-1:0] n,
   output logic [W-1:0]  res,
   output logic          clamped
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] mask;
   always_comb mask = (ONE << n) - ONE;

   generate
      if (SIGNED) begin : g_signed
         logic [W-1:0] hi;
         logic         too_big, too_small;
         always_comb begin
            hi        = $unsigned($signed(val) >>> n);
            too_big   = !hi[W-1] && (hi != '0);
            too_small =  hi[W-1] && (hi != '1);
            clamped   = too_big | too_small;
            if (too_big)        res = mask;
            else if (too_small) res = ~mask;
            else                res = val;
         end
      end else begin : g_unsigned
         always_comb begin
            if (val[W-1]) begin
               clamped = 1'b1;
               res     = '0;
            end else if (val > mask) begin
               clamped = 1'b1;
               res     = mask;
            end else begin
               clamped = 1'b0;
               res     = val;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sat_alu.sv
module sat_alu
   import sat_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int NW    = $clog2(DATA_W),
   localparam int HW    = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [NW-1:0]     sat_width,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] result,
   output logic              sat_flag
);
   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("sat_alu: DATA_W must be even and at least 4");
      end
   endgenerate

   logic [DATA_W-1:0] ar_res;
   logic              ar_clamp;

   sat_addsub #(.W(DATA_W)) u_arith (
      .op      (op),
      .a       (opa),
      .b       (opb),
      .res     (ar_res),
      .clamped (ar_clamp)
   );

   logic [DATA_W-1:0] ws_res, wu_res;
   logic              ws_clamp, wu_clamp;

   sat_clamp #(.W(DATA_W), .SIGNED(1'b1)) u_word_s (
      .val (opa), .n (sat_width), .res (ws_res), .clamped (ws_clamp)
   );
   sat_clamp #(.W(DATA_W), .SIGNED(1'b0)) u_word_u (
      .val (opa), .n (sat_width), .res (wu_res), .clamped (wu_clamp)
   );

   logic [DATA_W-1:0] hs_res, hu_res;
   logic [1:0]        hs_clamp, hu_clamp;

   generate
      for (genvar ln = 0; ln < 2; ln++) begin : g_lane
         logic [DATA_W-1:0] ext, rs, ru;
         always_comb ext = {{HW{opa[ln*HW + HW-1]}}, opa[ln*HW +: HW]};
         sat_clamp #(.W(DATA_W), .SIGNED(1'b1)) u_ls (
            .val (ext), .n (sat_width), .res (rs), .clamped (hs_clamp[ln])
         );
         sat_clamp #(.W(DATA_W), .SIGNED(1'b0)) u_lu (
            .val (ext), .n (sat_width), .res (ru), .clamped (hu_clamp[ln])
         );
         always_comb begin
            hs_res[ln*HW +: HW] = rs[HW-1:0];
            hu_res[ln*HW +: HW] = ru[HW-1:0];
         end
      end
   endgenerate

   logic [DATA_W-1:0] nxt_res;
   logic              nxt_clamp;

   always_comb begin
      case (op)
         OP_SADD, OP_SSUB, OP_SDBL, OP_UADD, OP_USUB: begin
            nxt_res = ar_res;  nxt_clamp = ar_clamp;
         end
         OP_SSAT:  begin nxt_res = ws_res; nxt_clamp = ws_clamp;  end
         OP_USAT:  begin nxt_res = wu_res; nxt_clamp = wu_clamp;  end
         OP_SSAT2: begin nxt_res = hs_res; nxt_clamp = |hs_clamp; end
         OP_USAT2: begin nxt_res = hu_res; nxt_clamp = |hu_clamp; end
         default:  begin nxt_res = '0;     nxt_clamp = 1'b0;      end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result   <= '0;
         sat_flag <= 1'b0;
      end else begin
         if (op_valid) result <= nxt_res;
         if (op_valid && nxt_clamp) sat_flag <= 1'b1;
         else if (flag_clr)         sat_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk
   import sat_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int NW    = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [OP_W-1:0]   op,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [NW-1:0]     sat_width,
   input logic              flag_clr,
   input logic [DATA_W-1:0] result,
   input logic              sat_flag
);
   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sat_flag) |-> $past(flag_clr));

   assert_flag_needs_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sat_flag) |-> $past(op_valid));

   assert_clamp_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && op_valid && op == OP_UADD && ({1'b0, opa} + {1'b0, opb}) > {1'b0, {DATA_W{1'b1}}})
      |=> sat_flag);

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(result));

   assert_uadd_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_UADD) |=> result >= $past(opa));

   assert_usub_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_USUB) |=> result <= $past(opa));

   assert_usat_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_USAT) |=> (result >> $past(sat_width)) == '0);
endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op        (op),
   .opa       (opa),
   .opb       (opb),
   .sat_width (sat_width),
   .flag_clr  (flag_clr),
   .result    (result),
   .sat_flag  (sat_flag)
);

// File: tb/sat_alu_bench.sv
`timescale 1ns/1ps
module sat_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] opa = '0, opb = '0;
   logic [4:0]  sat_width = '0;
   logic        flag_clr = 1'b0;
   logic [31:0] result;
   logic        sat_flag;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sat_alu u_sat_alu (
      .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op (op),
      .opa (opa), .opb (opb), .sat_width (sat_width), .flag_clr (flag_clr),
      .result (result), .sat_flag (sat_flag)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [4:0]  n;
      logic [31:0] r;
      logic        c;
   } vec_t;

   localparam int NV = 40;
   localparam vec_t VECS [NV] = '{
      '{4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b1},
      '{4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0,  32'h80000000, 1'b1},
      '{4'd0, 32'h00000005, 32'hFFFFFFFD, 5'd0,  32'h00000002, 1'b0},
      '{4'd1, 32'h80000000, 32'h00000001, 5'd0,  32'h80000000, 1'b1},
      '{4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0,  32'h7FFFFFFF, 1'b1},
      '{4'd1, 32'h0000000A, 32'h00000003, 5'd0,  32'h00000007, 1'b0},
      '{4'd2, 32'h40000000, 32'h0,        5'd0,  32'h7FFFFFFF, 1'b1},
      '{4'd2, 32'h3FFFFFFF, 32'h0,        5'd0,  32'h7FFFFFFE, 1'b0},
      '{4'd2, 32'hC0000000, 32'h0,        5'd0,  32'h80000000, 1'b1},
      '{4'd2, 32'hC0000001, 32'h0,        5'd0,  32'h80000002, 1'b0},
      '{4'd3, 32'hFFFFFFF0, 32'h00000020, 5'd0,  32'hFFFFFFFF, 1'b1},
      '{4'd3, 32'h00000010, 32'h00000020, 5'd0,  32'h00000030, 1'b0},
      '{4'd4, 32'h00000005, 32'h00000006, 5'd0,  32'h00000000, 1'b1},
      '{4'd4, 32'h00000006, 32'h00000005, 5'd0,  32'h00000001, 1'b0},
      '{4'd5, 32'h00000100, 32'h0,        5'd7,  32'h0000007F, 1'b1},
      '{4'd5, 32'hFFFFFF00, 32'h0,        5'd7,  32'hFFFFFF80, 1'b1},
      '{4'd5, 32'h0000007F, 32'h0,        5'd7,  32'h0000007F, 1'b0},
      '{4'd5, 32'hFFFFFF80, 32'h0,        5'd7,  32'hFFFFFF80, 1'b0},
      '{4'd5, 32'h00000001, 32'h0,        5'd0,  32'h00000000, 1'b1},
      '{4'd5, 32'hFFFFFFFF, 32'h0,        5'd0,  32'hFFFFFFFF, 1'b0},
      '{4'd5, 32'hFFFFFFFE, 32'h0,        5'd0,  32'hFFFFFFFF, 1'b1},
      '{4'd5, 32'h80000000, 32'h0,        5'd31, 32'h80000000, 1'b0},
      '{4'd5, 32'h7FFFFFFF, 32'h0,        5'd31, 32'h7FFFFFFF, 1'b0},
      '{4'd6, 32'hFFFFFFFF, 32'h0,        5'd8,  32'h00000000, 1'b1},
      '{4'd6, 32'h00000100, 32'h0,        5'd8,  32'h000000FF, 1'b1},
      '{4'd6, 32'h000000FF, 32'h0,        5'd8,  32'h000000FF, 1'b0},
      '{4'd6, 32'h00000001, 32'h0,        5'd0,  32'h00000000, 1'b1},
      '{4'd6, 32'h00000000, 32'h0,        5'd0,  32'h00000000, 1'b0},
      '{4'd6, 32'h7FFFFFFF, 32'h0,        5'd31, 32'h7FFFFFFF, 1'b0},
      '{4'd6, 32'h80000000, 32'h0,        5'd31, 32'h00000000, 1'b1},
      '{4'd7, 32'h7FFF8000, 32'h0,        5'd7,  32'h007FFF80, 1'b1},
      '{4'd7, 32'h0005FFFB, 32'h0,        5'd7,  32'h0005FFFB, 1'b0},
      '{4'd7, 32'h80007FFF, 32'h0,        5'd31, 32'h80007FFF, 1'b0},
      '{4'd7, 32'h0001FFFF, 32'h0,        5'd0,  32'h0000FFFF, 1'b1},
      '{4'd7, 32'h00030100, 32'h0,        5'd3,  32'h00030007, 1'b1},
      '{4'd8, 32'hFFFF0100, 32'h0,        5'd8,  32'h000000FF, 1'b1},
      '{4'd8, 32'h00800010, 32'h0,        5'd8,  32'h00800010, 1'b0},
      '{4'd8, 32'h80007FFF, 32'h0,        5'd31, 32'h00007FFF, 1'b1},
      '{4'd8, 32'h00000000, 32'h0,        5'd0,  32'h00000000, 1'b0},
      '{4'd9, 32'h00001234, 32'h00005678, 5'd4,  32'h00000000, 1'b0}
   };

   function automatic string tag_of(input logic [3:0] o);
      case (o)
         4'd0, 4'd1: return "R2";
         4'd2:       return "R3";
         4'd3, 4'd4: return "R4";
         4'd5:       return "R5";
         4'd6:       return "R6";
         4'd7, 4'd8: return "R7";
         default:    return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] n, input logic clr);
      op_valid = v; op = o; opa = a; opb = b; sat_width = n; flag_clr = clr;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1", "reset result", result, 32'h0);
      check("R1", "reset flag", {31'b0, sat_flag}, 32'h0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // Table walk: clear on every vector, so flag equals that vector's clamp (R9 priority)
      for (int i = 0; i < NV; i++) begin
         step(1'b1, VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].n, 1'b1);
         check(tag_of(VECS[i].op), $sformatf("vec %0d result", i), result, VECS[i].r);
         check(tag_of(VECS[i].op), $sformatf("vec %0d flag", i),
               {31'b0, sat_flag}, {31'b0, VECS[i].c});
      end

      // R9: clear alone
      step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
      check("R9", "clear alone", {31'b0, sat_flag}, 32'h0);

      // R8: invalid clamping op does not set the flag; R10: result held
      step(1'b0, 4'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b0);
      check("R8", "idle clamp no flag", {31'b0, sat_flag}, 32'h0);
      check("R10", "idle hold", result, 32'h0);

      // R8: clamp sets flag, later clean ops keep it
      step(1'b1, 4'd4, 32'h1, 32'h2, 5'd0, 1'b0);
      check("R8", "flag set", {31'b0, sat_flag}, 32'h1);
      step(1'b1, 4'd3, 32'h1, 32'h2, 5'd0, 1'b0);
      check("R8", "flag sticky 1", {31'b0, sat_flag}, 32'h1);
      check("R4", "clean uadd", result, 32'h3);
      step(1'b1, 4'd5, 32'h5, 32'h0, 5'd31, 1'b0);
      check("R8", "flag sticky 2", {31'b0, sat_flag}, 32'h1);

      // R10: hold while idle with new operands
      step(1'b0, 4'd0, 32'h11111111, 32'h22222222, 5'd0, 1'b0);
      check("R10", "hold with new inputs", result, 32'h5);

      // R9: simultaneous clamp and clear keeps flag set
      step(1'b1, 4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1'b1);
      check("R9", "set beats clear", {31'b0, sat_flag}, 32'h1);
      step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
      check("R9", "clear after", {31'b0, sat_flag}, 32'h0);

      // R1: reset mid-run
      step(1'b1, 4'd6, 32'hFFFFFFFF, 32'h0, 5'd4, 1'b0);
      rst_n = 1'b0;
      #1;
      check("R1", "async reset result", result, 32'h0);
      check("R1", "async reset flag", {31'b0, sat_flag}, 32'h0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule